// File: doc/BRIEF.md
# Sixteen-Pin I/O Bank with Interrupt Capture

This block is one bank of general-purpose pins with a small register interface. For every pin it holds a direction bit, an output value and an alternate-function select. It also holds the interrupt setup for each pin: a mask, a choice of edge or level trigger, and a polarity for each trigger kind. Pad inputs pass through a synchroniser before anything reads them. Software can read the live synchronised levels.

Each pin whose trigger condition is met sets a bit in a sticky status register. The host clears status bits by writing zeros to that register. The bank raises one interrupt request towards a parent aggregator whenever any unmasked status bit is set. A complete device places four of these banks side by side.

Top module: `pinbank_irq`

## Requirements
- R1: While reset is asserted, and on release, the mask register reads 0xFFFF. Every other writable register reads 0x0000, and `pin_oe`, `pin_out`, `alt_sel` and `bank_irq` are all 0.
- R2: When `host_wr` is high at a clock edge, the register at `host_addr` takes `host_wdata`. The register map is 0 direction, 1 output, 2 alternate-function, 3 mask, 4 trigger-type, 5 edge-polarity, 6 level-polarity, 7 status and 8 pin-level. `host_rdata` shows the addressed register combinationally. Addresses 9 to 15 read 0 and ignore writes. The pin-level register is read-only.
- R3: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals the output register.
- R4: `alt_sel` equals the alternate-function register, where 1 hands the pin to another peripheral.
- R5: The pin-level register returns `pin_in` delayed by a two-flop synchroniser. A change made before a clock edge shows on the second edge after it.
- R6: A pin with trigger-type 1 and edge-polarity 1 sets its status bit on a rising edge only. The bit is visible on the third clock edge after the pad change.
- R7: A pin with trigger-type 1 and edge-polarity 0 sets its status bit on a falling edge only.
- R8: A pin with trigger-type 0 sets its status bit on every cycle its synchronised level equals its level-polarity bit, where 1 means high. A clear written while the level is still active has no lasting effect.
- R9: A write to the status register clears each bit written as 0 and keeps each bit written as 1. A trigger in the same cycle as the write wins, and its bit stays set.
- R10: `bank_irq` is high exactly when some status bit is set while its mask bit is 0. A mask bit of 1 disables that pin.
- R11: Status bits latch whatever the mask holds, so a masked pin's event stays visible in the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for `host_addr` |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Output values towards the pads |
| pin_oe | output | 16 | Output enables, where 1 means drive |
| alt_sel | output | 16 | Alternate-function selects |
| bank_irq | output | 1 | Bank interrupt request |

## Verification
On every cycle, the assertions check four properties:
- the synchroniser delay;
- that a trigger hit always lands in status on the next edge;
- that status bits never drop without a status write, and that a write of zero with no hit empties status;
- that the mask register holds steady without a write.

Other behaviours show only in the bench's scenarios, because they need a chosen pin sequence to expose them:
- a pad edge of the wrong polarity is ignored;
- a level source re-arms after a clear;
- a hit and a clear in the same cycle resolve in favour of the hit;
- masking gates the request but not the status.

// File: rtl/pinbank_pkg.sv
`timescale 1ns/1ps
package pinbank_pkg;
  localparam int unsigned ADDR_W = 4;
  // register map; the host decodes these offsets
  localparam logic [ADDR_W-1:0] RA_DIR  = 4'h0;
  localparam logic [ADDR_W-1:0] RA_OUT  = 4'h1;
  localparam logic [ADDR_W-1:0] RA_ALT  = 4'h2;
  localparam logic [ADDR_W-1:0] RA_MASK = 4'h3;
  localparam logic [ADDR_W-1:0] RA_TRIG = 4'h4;
  localparam logic [ADDR_W-1:0] RA_EPOL = 4'h5;
  localparam logic [ADDR_W-1:0] RA_LPOL = 4'h6;
  localparam logic [ADDR_W-1:0] RA_STAT = 4'h7;
  localparam logic [ADDR_W-1:0] RA_LVL  = 4'h8;
endpackage

// File: rtl/pinbank_rstsync.sv
`timescale 1ns/1ps
module pinbank_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_sync_n = rs_q[1];
endmodule

// File: rtl/pinbank_sync.sv
`timescale 1ns/1ps
module pinbank_sync #(
  parameter int unsigned NPIN   = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_raw,
  output logic [NPIN-1:0] sync_lvl
);
  logic [NPIN-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [NPIN-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = pin_raw;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign sync_lvl = stage_q[STAGES-1];

  // cycles since reset, so the delay check never looks before it
  logic [1:0] age_q;
  logic [1:0] age_d;
  always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else        age_q <= age_d;
  end

  if (STAGES == 2) begin : g_chk
    // R5
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3) |-> (sync_lvl == $past(pin_raw, 2)));
  end
endmodule

// File: rtl/pinbank_cfg.sv
`timescale 1ns/1ps
module pinbank_cfg
  import pinbank_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [NPIN-1:0]   host_wdata,
  input  logic [NPIN-1:0]   status_in,
  input  logic [NPIN-1:0]   level_in,
  output logic [NPIN-1:0]   host_rdata,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   out_o,
  output logic [NPIN-1:0]   alt_o,
  output logic [NPIN-1:0]   mask_o,
  output logic [NPIN-1:0]   trig_o,
  output logic [NPIN-1:0]   epol_o,
  output logic [NPIN-1:0]   lpol_o,
  output logic              stat_wr
);
  logic en_dir, en_out, en_alt, en_mask, en_trig, en_epol, en_lpol;

  // write enables, one per register
  always_comb begin
    en_dir  = host_wr && (host_addr == RA_DIR);
    en_out  = host_wr && (host_addr == RA_OUT);
    en_alt  = host_wr && (host_addr == RA_ALT);
    en_mask = host_wr && (host_addr == RA_MASK);
    en_trig = host_wr && (host_addr == RA_TRIG);
    en_epol = host_wr && (host_addr == RA_EPOL);
    en_lpol = host_wr && (host_addr == RA_LPOL);
    stat_wr = host_wr && (host_addr == RA_STAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o  <= '0;
      out_o  <= '0;
      alt_o  <= '0;
      mask_o <= '1;
      trig_o <= '0;
      epol_o <= '0;
      lpol_o <= '0;
    end else begin
      if (en_dir)  dir_o  <= host_wdata;
      if (en_out)  out_o  <= host_wdata;
      if (en_alt)  alt_o  <= host_wdata;
      if (en_mask) mask_o <= host_wdata;
      if (en_trig) trig_o <= host_wdata;
      if (en_epol) epol_o <= host_wdata;
      if (en_lpol) lpol_o <= host_wdata;
    end
  end

  always_comb begin
    case (host_addr)
      RA_DIR:  host_rdata = dir_o;
      RA_OUT:  host_rdata = out_o;
      RA_ALT:  host_rdata = alt_o;
      RA_MASK: host_rdata = mask_o;
      RA_TRIG: host_rdata = trig_o;
      RA_EPOL: host_rdata = epol_o;
      RA_LPOL: host_rdata = lpol_o;
      RA_STAT: host_rdata = status_in;
      RA_LVL:  host_rdata = level_in;
      default: host_rdata = '0;
    endcase
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(mask_o));
endmodule

// File: rtl/pinbank_detect.sv
`timescale 1ns/1ps
module pinbank_detect #(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] sync_lvl,
  input  logic [NPIN-1:0] trig,
  input  logic [NPIN-1:0] epol,
  input  logic [NPIN-1:0] lpol,
  input  logic            stat_wr,
  input  logic [NPIN-1:0] stat_wdata,
  output logic [NPIN-1:0] status_q
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] status_d;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    always_comb begin
      rise     = sync_lvl[p] & ~prev_q[p];
      fall     = ~sync_lvl[p] & prev_q[p];
      edge_hit = trig[p] & (epol[p] ? rise : fall);
      lvl_hit  = ~trig[p] & (lpol[p] ? sync_lvl[p] : ~sync_lvl[p]);
      hit[p]   = edge_hit | lvl_hit;
    end
  end

  // a hit overrides a clear in the same cycle
  always_comb begin
    status_d = (stat_wr ? (status_q & stat_wdata) : status_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_lvl;
      status_q <= status_d;
    end
  end

  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && (stat_wdata == '0) && (hit == '0)) |=> (status_q == '0));

  // R6
  hit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/pinbank_irq.sv
`timescale 1ns/1ps
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter int unsigned NPIN   = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [NPIN-1:0]   host_wdata,
  output logic [NPIN-1:0]   host_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   alt_sel,
  output logic              bank_irq
);
  logic            rst_i_n;
  logic [NPIN-1:0] sync_lvl;
  logic [NPIN-1:0] status_q;
  logic [NPIN-1:0] mask_r, trig_r, epol_r, lpol_r;
  logic            stat_wr;

  pinbank_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pinbank_sync #(.NPIN(NPIN), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .pin_raw  (pin_in),
    .sync_lvl (sync_lvl)
  );

  pinbank_cfg #(.NPIN(NPIN)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .status_in  (status_q),
    .level_in   (sync_lvl),
    .host_rdata (host_rdata),
    .dir_o      (pin_oe),
    .out_o      (pin_out),
    .alt_o      (alt_sel),
    .mask_o     (mask_r),
    .trig_o     (trig_r),
    .epol_o     (epol_r),
    .lpol_o     (lpol_r),
    .stat_wr    (stat_wr)
  );

  pinbank_detect #(.NPIN(NPIN)) u_det (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .sync_lvl   (sync_lvl),
    .trig       (trig_r),
    .epol       (epol_r),
    .lpol       (lpol_r),
    .stat_wr    (stat_wr),
    .stat_wdata (host_wdata),
    .status_q   (status_q)
  );

  assign bank_irq = |(status_q & ~mask_r);
endmodule

// File: tb/pinbank_irq_bench.sv
`timescale 1ns/1ps
module pinbank_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [3:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out, pin_oe, alt_sel;
  logic        bank_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pinbank_irq u_pinbank_irq (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel), .bank_irq(bank_irq)
  );

  // {address, write data, expected readback}
  localparam logic [35:0] VEC [0:7] = '{
    {4'h0, 16'hA5A5, 16'hA5A5},
    {4'h1, 16'h1234, 16'h1234},
    {4'h2, 16'h00FF, 16'h00FF},
    {4'h5, 16'h5555, 16'h5555},
    {4'h6, 16'h0F0F, 16'h0F0F},
    {4'h4, 16'hF0F0, 16'hF0F0},
    {4'h3, 16'h8001, 16'h8001},
    {4'hC, 16'h1111, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; host_wr = 1'b0; host_addr = 4'h0; host_wdata = 16'h0; pin_in = 16'h0;
    edges(3);
    @(negedge clk);
    check("R1 pin_oe in reset", pin_oe, 16'h0);
    check("R1 irq in reset", {15'b0, bank_irq}, 16'h0);
    check("R1 alt_sel/pin_out in reset", alt_sel | pin_out, 16'h0);
    rst_n = 1'b1;
    edges(6);
    rd(4'h3, v); check("R1 mask reset", v, 16'hFFFF);
    rd(4'h0, v); check("R1 dir reset", v, 16'h0000);
    // default level-low trigger on low pins latches every bit (R8, R11)
    rd(4'h7, v); check("R8 level-low default status", v, 16'hFFFF);
    check("R10 all masked, irq low", {15'b0, bank_irq}, 16'h0);

    // R2 table walk
    for (int i = 0; i < 8; i++) wr(VEC[i][35:32], VEC[i][31:16]);
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][35:32], v);
      check($sformatf("R2 readback addr %0h", VEC[i][35:32]), v, VEC[i][15:0]);
    end
    check("R3 pin_oe", pin_oe, 16'hA5A5);
    check("R3 pin_out", pin_out, 16'h1234);
    check("R4 alt_sel", alt_sel, 16'h00FF);
    wr(4'h8, 16'hFFFF);
    rd(4'h8, v); check("R2 pin-level read-only", v, 16'h0000);

    // edge mode: pins 0-7 rising, 8-15 falling
    wr(4'h4, 16'hFFFF);
    wr(4'h5, 16'h00FF);
    wr(4'h3, 16'h0000);
    edges(3);
    wr(4'h7, 16'h0000);
    rd(4'h7, v); check("R9 clear by zero write", v, 16'h0000);
    check("R10 irq low with empty status", {15'b0, bank_irq}, 16'h0);

    @(negedge clk); pin_in = 16'h0001;
    edges(2); @(negedge clk); host_addr = 4'h8; #1;
    check("R5 level after two edges", host_rdata, 16'h0001);
    host_addr = 4'h7; #1;
    check("R6 status not yet set", host_rdata, 16'h0000);
    edges(1); @(negedge clk); #1;
    check("R6 rising edge latched", host_rdata, 16'h0001);
    check("R10 irq raised", {15'b0, bank_irq}, 16'h0001);

    // wrong-direction edges are ignored
    @(negedge clk); pin_in = 16'h0100;
    edges(4);
    rd(4'h7, v); check("R6 R7 wrong edges ignored", v, 16'h0001);
    @(negedge clk); pin_in = 16'h0000;
    edges(4);
    rd(4'h7, v); check("R7 falling edge latched", v, 16'h0101);

    wr(4'h7, 16'h0100);
    rd(4'h7, v); check("R9 partial clear", v, 16'h0100);

    wr(4'h3, 16'h0100);
    check("R10 masked bit no irq", {15'b0, bank_irq}, 16'h0);
    wr(4'h3, 16'hFFFF);
    @(negedge clk); pin_in = 16'h0004;
    edges(4);
    rd(4'h7, v); check("R11 masked pin still latches", v, 16'h0104);
    check("R10 irq low while masked", {15'b0, bank_irq}, 16'h0);
    wr(4'h3, 16'h0000);
    check("R10 irq on unmask", {15'b0, bank_irq}, 16'h0001);

    // level-high on pin 15
    wr(4'h7, 16'h0000);
    wr(4'h6, 16'h8000);
    wr(4'h4, 16'h7FFF);
    wr(4'h7, 16'h0000);
    rd(4'h7, v); check("R8 inactive level no status", v, 16'h0000);
    @(negedge clk); pin_in = 16'h8004;
    edges(4);
    rd(4'h7, v); check("R8 level-high latched", v, 16'h8000);
    wr(4'h7, 16'h0000);
    rd(4'h7, v); check("R8 re-set while active", v, 16'h8000);
    @(negedge clk); pin_in = 16'h0004;
    edges(4);
    wr(4'h7, 16'h0000);
    rd(4'h7, v); check("R8 clears once inactive", v, 16'h0000);

    // hit and clear in the same cycle: hit wins
    @(negedge clk); pin_in = 16'h0006;
    edges(2);
    wr(4'h7, 16'h0000);
    rd(4'h7, v); check("R9 hit beats clear", v, 16'h0002);

    // reset mid-run
    @(negedge clk); rst_n = 1'b0;
    rd(4'h3, v); check("R1 mask after reset", v, 16'hFFFF);
    rd(4'h4, v); check("R1 trig after reset", v, 16'h0000);
    check("R1 irq after reset", {15'b0, bank_irq}, 16'h0);
    rst_n = 1'b1;
    edges(2);
    summary();
    $finish;
  end
endmodule